// File: doc/BRIEF.md
# Capture-Compare Timer

This block is an up-counting timer with a small register port. Software picks a tick source and a divide ratio, then starts the count. The count runs in one of two modes. In free-run mode it wraps from all-ones to zero and records a rollover. In restart mode it returns to zero after it matches the first compare value.

There are three compare channels. Each one compares the count against its own value, sets its own event flag when the count reaches that value, and drives an output pin. The pin action for each channel is set by a mode field. There are two capture channels. Each one synchronises its input pin and, on the selected edge, stores the count and sets its own event flag.

Software clears event flags by writing one to them. Each flag has its own interrupt enable bit, and the interrupt output is the OR of all flags that are enabled. A soft reset bit returns every register to its default value. The block can also load zero into the count each time counting is started.

Top module: `capcmp_timer`

## Requirements
- R1: After reset, every register reads 0, all compare pins are 0 and `irq` is 0. The register word addresses are: 0 control, 1 divider, 2 flags, 3 interrupt enable, 4 to 6 compare values 1 to 3, 7 and 8 capture values 1 and 2, 9 current count (read only). A read returns the addressed register one cycle after the address is presented.
- R2: The flags register holds these events: bit 0 to bit 2 are compare 1 to 3, bits 3 and 4 are capture 1 and 2, and bit 5 is rollover. Writing 1 to a flag bit clears it. Writing 0 to a flag bit leaves it unchanged.
- R3: The control source field is bits 6:4. Code 0, and codes 5 to 7, stop the count. Codes 1 to 3 tick on every clock. Code 4 ticks on each cycle that `ref_tick` is high. With control bit 0 (run) set, the count advances by one every divider+1 ticks, and by no other amount.
- R4: When control bit 7 is 1 (free-run), the count goes from all-ones to 0 and sets flag bit 5.
- R5: When control bit 7 is 0 (restart), a tick taken while the count equals compare value 1 loads 0 into the count. Compare values 2 and 3 never restart the count.
- R6: A compare channel sets its flag when a tick brings the count to that channel's value.
- R7: Each compare pin has a 3-bit mode field: channel 1 uses bits 15:13, channel 2 uses bits 18:16 and channel 3 uses bits 21:19. The modes are: 000 holds the pin at 0; 001 toggles the pin on a match; 010 clears it on a match; 011 sets it on a match; 1xx keeps the pin high and drives it low for the single cycle after a match.
- R8: Each capture channel has a 2-bit mode field: channel 1 uses bits 10:9 and channel 2 uses bits 12:11. The modes are 00 off, 01 rising edge, 10 falling edge and 11 both edges. On a selected edge of the synchronised input, the channel stores the count and sets its flag. Edges that the mode does not select have no effect.
- R9: Control bit 1 is zero-on-start. When it is 1, a 0-to-1 change of the run bit clears both the count and the prescaler. When it is 0, the count keeps its held value across the change.
- R10: Writing 1 to control bit 8 starts a soft reset. While the reset is in progress, control bit 8 reads back as 1. Within a few cycles every register returns to 0 and bit 8 clears.
- R11: `irq` is high when any flag bit and the enable bit at the same position are both set. It follows a change of the flags or the enables within two cycles.
- R12: A new divider value applies from the next tick. A prescaler count already past the new limit ends the current tick period at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ref_tick | input | 1 | Low-frequency tick input, one clock wide, already in the clock domain |
| cap_in | input | 2 | Capture input pins |
| cmp_out | output | 3 | Compare output pins |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check four rules on every cycle. The count only steps by one or returns to zero. A rollover flag only rises after the count was all-ones. In restart mode a count that changes after equalling compare value 1 becomes zero. While a soft reset is in progress, the flags and the count stay cleared. Other behaviour can only be shown by the bench scenarios. These cover the exact tick rates for each divider and source, the pin sequences of each compare mode, the capture response to each of the two edges in each of the four modes, the write-one-to-clear masks, the interrupt gating, and the read-back of a soft reset in progress.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int NCMP   = 3;
  localparam int NCAP   = 2;
  localparam int NUM_EV = NCMP + NCAP + 1;
  localparam int EV_CAP = NCMP;
  localparam int EV_ROLL = NCMP + NCAP;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_DIV   = 4'd1;
  localparam logic [ADDR_W-1:0] A_FLAGS = 4'd2;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd3;
  localparam logic [ADDR_W-1:0] A_CMP0  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CAP0  = 4'd7;
  localparam logic [ADDR_W-1:0] A_COUNT = 4'd9;

  typedef struct packed {
    logic [2:0] om3;
    logic [2:0] om2;
    logic [2:0] om1;
    logic [1:0] im2;
    logic [1:0] im1;
    logic       srst;
    logic       freerun;
    logic [2:0] src;
    logic       stop_keep;
    logic       wait_keep;
    logic       zero_on_start;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int SRST_BIT = 8;
endpackage

// File: rtl/capcmp_tick.sv
module capcmp_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clear,
  input  logic [2:0]       src,
  input  logic             ref_tick,
  input  logic [DIV_W-1:0] div,
  output logic             adv
);
  logic             base;
  logic [DIV_W-1:0] pcnt;
  logic             hit;

  always_comb begin
    case (src)
      3'd1, 3'd2, 3'd3: base = 1'b1;
      3'd4:             base = ref_tick;
      default:          base = 1'b0;
    endcase
  end

  assign hit = (pcnt >= div);
  assign adv = run & base & hit & ~clear;

  always_ff @(posedge clk) begin
    if (rst || clear) pcnt <= '0;
    else if (run && base) pcnt <= hit ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/capcmp_capture.sv
module capcmp_capture #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] cnt,
  output logic             hit,
  output logic [CNT_W-1:0] value
);
  logic s1, s2, prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0; s2 <= 1'b0; prev <= 1'b0;
    end else begin
      s1 <= pin; s2 <= s1; prev <= s2;
    end
  end

  assign hit = (mode[0] & s2 & ~prev) | (mode[1] & ~s2 & prev);

  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else if (hit) value <= cnt;
  end
endmodule

// File: rtl/capcmp_compare.sv
module capcmp_compare (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       match,
  output logic       pin
);
  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else begin
      casez (mode)
        3'b000: pin <= 1'b0;
        3'b001: if (match) pin <= ~pin;
        3'b010: if (match) pin <= 1'b0;
        3'b011: if (match) pin <= 1'b1;
        default: pin <= ~match;
      endcase
    end
  end
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int DIV_W    = 12,
  parameter int SRST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ref_tick,
  input  logic [NCAP-1:0]   cap_in,
  output logic [NCMP-1:0]   cmp_out,
  output logic              irq
);
  localparam int SR_W = $clog2(SRST_CYC + 1);

  logic [SR_W-1:0]   sr_cnt;
  logic              busy, lrst, we;
  ctrl_t             ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [NUM_EV-1:0] flags_q, ien_q, set_vec, w1c;
  logic [CNT_W-1:0]  cnt_q, next_cnt;
  logic [CNT_W-1:0]  cmp_q [NCMP];
  logic [CNT_W-1:0]  cap_val [NCAP];
  logic [NCMP-1:0]   match;
  logic [NCAP-1:0]   cap_hit;
  logic [1:0]        cap_mode [NCAP];
  logic [2:0]        cmp_mode [NCMP];
  logic              run_d, clr_en, adv, restart, roll;
  logic [DATA_W-1:0] rd_mux;

  assign busy = (sr_cnt != '0);
  assign lrst = rst | busy;
  assign we   = wr_en & ~busy;

  always_ff @(posedge clk) begin
    if (rst) sr_cnt <= '0;
    else if (we && addr == A_CTRL && wdata[SRST_BIT]) sr_cnt <= SR_W'(SRST_CYC);
    else if (busy) sr_cnt <= sr_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (lrst) begin
      ctrl_q <= '0;
      div_q  <= '0;
      ien_q  <= '0;
      run_d  <= 1'b0;
    end else begin
      run_d <= ctrl_q.run;
      if (we && addr == A_CTRL && !wdata[SRST_BIT]) begin
        ctrl_q      <= ctrl_t'(wdata[CTRL_W-1:0]);
        ctrl_q.srst <= 1'b0;
      end
      if (we && addr == A_DIV) div_q <= wdata[DIV_W-1:0];
      if (we && addr == A_IEN) ien_q <= wdata[NUM_EV-1:0];
    end
  end

  assign clr_en = ctrl_q.run & ~run_d & ctrl_q.zero_on_start;

  capcmp_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(lrst), .run(ctrl_q.run), .clear(clr_en),
    .src(ctrl_q.src), .ref_tick(ref_tick), .div(div_q), .adv(adv)
  );

  assign restart  = ~ctrl_q.freerun & (cnt_q == cmp_q[0]);
  assign next_cnt = restart ? '0 : cnt_q + 1'b1;
  assign roll     = adv & ~restart & (&cnt_q);

  always_ff @(posedge clk) begin
    if (lrst || clr_en) cnt_q <= '0;
    else if (adv) cnt_q <= next_cnt;
  end

  assign cap_mode[0] = ctrl_q.im1;
  assign cap_mode[1] = ctrl_q.im2;
  assign cmp_mode[0] = ctrl_q.om1;
  assign cmp_mode[1] = ctrl_q.om2;
  assign cmp_mode[2] = ctrl_q.om3;

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (lrst) cmp_q[i] <= '0;
      else if (we && addr == ADDR_W'(A_CMP0 + i)) cmp_q[i] <= wdata[CNT_W-1:0];
    end
    assign match[i] = adv & (next_cnt == cmp_q[i]);
    capcmp_compare u_cmp (
      .clk(clk), .rst(lrst), .mode(cmp_mode[i]), .match(match[i]), .pin(cmp_out[i])
    );
  end

  for (genvar j = 0; j < NCAP; j++) begin : g_cap
    capcmp_capture #(.CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst(lrst), .pin(cap_in[j]), .mode(cap_mode[j]),
      .cnt(cnt_q), .hit(cap_hit[j]), .value(cap_val[j])
    );
  end

  assign set_vec = {roll, cap_hit, match};
  assign w1c     = (we && addr == A_FLAGS) ? wdata[NUM_EV-1:0] : '0;

  always_ff @(posedge clk) begin
    if (lrst) flags_q <= '0;
    else flags_q <= (flags_q & ~w1c) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (lrst) irq <= 1'b0;
    else irq <= |(flags_q & ien_q);
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL: begin
        rd_mux[CTRL_W-1:0] = ctrl_q;
        rd_mux[SRST_BIT]   = busy;
      end
      A_DIV:   rd_mux[DIV_W-1:0]  = div_q;
      A_FLAGS: rd_mux[NUM_EV-1:0] = flags_q;
      A_IEN:   rd_mux[NUM_EV-1:0] = ien_q;
      A_COUNT: rd_mux[CNT_W-1:0]  = cnt_q;
      default: begin
        for (int k = 0; k < NCMP; k++)
          if (addr == ADDR_W'(A_CMP0 + k)) rd_mux[CNT_W-1:0] = cmp_q[k];
        for (int k = 0; k < NCAP; k++)
          if (addr == ADDR_W'(A_CAP0 + k)) rd_mux[CNT_W-1:0] = cap_val[k];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else rdata <= rd_mux;
  end
endmodule

// File: rtl/capcmp_checker.sv
module capcmp_checker #(
  parameter int CNT_W = 32,
  parameter int NUM_EV = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp1,
  input logic              freerun,
  input logic [NUM_EV-1:0] flags,
  input logic              busy
);
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1) || cnt == '0));

  // R4
  roll_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[NUM_EV-1]) |-> ($past(cnt) == {CNT_W{1'b1}}));

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(freerun) && $past(cnt) == $past(cmp1) && cnt != $past(cnt)) |-> (cnt == '0));

  // R10
  srst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (flags == '0 && cnt == '0));
endmodule

bind capcmp_timer capcmp_checker #(.CNT_W(CNT_W), .NUM_EV(capcmp_pkg::NUM_EV)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt_q), .cmp1(cmp_q[0]),
  .freerun(ctrl_q.freerun), .flags(flags_q), .busy(busy)
);

// File: tb/sim_capcmp_timer.sv
`timescale 1ns/1ps
module sim_capcmp_timer;
  localparam int CW = 8;
  logic clk = 0, rst = 1, wr_en = 0, ref_tick = 0, irq;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [1:0] cap_in = 0;
  logic [2:0] cmp_out;
  int n_chk = 0, n_fail = 0, tdiv = 0;
  logic [31:0] v, c1, c2;

  capcmp_timer #(.CNT_W(CW), .DIV_W(8), .SRST_CYC(4)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ref_tick(ref_tick), .cap_in(cap_in), .cmp_out(cmp_out), .irq(irq));

  always #4 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tdiv = tdiv + 1;
    ref_tick = (tdiv % 4 == 0);
  end

  function automatic logic [31:0] cw(input int run, zs, src, fr, im1, im2, om1, om2, om3);
    return 32'(run) | 32'(zs << 1) | 32'(src << 4) | 32'(fr << 7) | 32'(im1 << 9) |
           32'(im2 << 11) | 32'(om1 << 13) | 32'(om2 << 16) | 32'(om3 << 19);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); wr_en = 0; addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // count increments over exactly k clock edges
  task automatic cdiff(input int k, output logic [31:0] d);
    logic [31:0] a, b;
    rd(4'd9, a); waitc(k - 2); rd(4'd9, b);
    d = (b - a) & 32'hFF;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    waitc(4); rst = 0; waitc(1);
    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v); chk(v == 0, $sformatf("R1 reg %0d", a), v, 0);
    end
    chk(cmp_out == 0 && irq == 0, "R1 pins", {28'd0, irq, cmp_out}, 0);

    // R3 divider sweep with every-clock source
    for (int d = 0; d < 4; d++) begin
      wr(4'd1, 32'(d)); wr(4'd0, cw(1,0,1,1,0,0,0,0,0));
      cdiff(12, v); chk(v == 32'(12 / (d + 1)), $sformatf("R3 div %0d", d), v, 32'(12 / (d + 1)));
      wr(4'd0, 0);
    end
    // R3 reference tick source
    for (int d = 0; d < 2; d++) begin
      wr(4'd1, 32'(d)); wr(4'd0, cw(1,0,4,1,0,0,0,0,0));
      cdiff(24, v); chk(v == 32'(6 / (d + 1)), "R3 ref src", v, 32'(6 / (d + 1)));
    end
    // R3 stopped sources
    wr(4'd0, cw(1,0,0,1,0,0,0,0,0)); cdiff(12, v); chk(v == 0, "R3 src0", v, 0);
    wr(4'd0, cw(1,0,5,1,0,0,0,0,0)); cdiff(12, v); chk(v == 0, "R3 src5", v, 0);

    // R12 divider change applies at once
    wr(4'd1, 200); wr(4'd0, cw(1,0,1,1,0,0,0,0,0));
    cdiff(8, v); chk(v == 0, "R12 slow", v, 0);
    wr(4'd1, 0); cdiff(8, v); chk(v == 8, "R12 fast", v, 8);

    // R9 zero-on-start versus resume
    wr(4'd0, 0); rd(4'd9, c1);
    wr(4'd0, cw(1,0,0,1,0,0,0,0,0)); rd(4'd9, v); chk(v == c1, "R9 resume", v, c1);
    wr(4'd0, 0);
    wr(4'd0, cw(1,1,0,1,0,0,0,0,0)); rd(4'd9, v); chk(v == 0, "R9 zero", v, 0);

    // R4 rollover, R2 write-one-to-clear
    wr(4'd2, 32'h3F); wr(4'd0, 0);
    wr(4'd0, cw(1,1,1,1,0,0,0,0,0));
    waitc(180); rd(4'd2, v); chk(v[5] == 0, "R4 no roll yet", v, 0);
    waitc(100); rd(4'd2, v); chk(v[5] == 1, "R4 roll", v, 32'h20);
    wr(4'd0, 0);
    wr(4'd2, 0); rd(4'd2, v); chk(v == 32'h27, "R2 zero write", v, 32'h27);
    wr(4'd2, 32'h20); rd(4'd2, v); chk(v == 32'h07, "R2 clear one", v, 32'h07);
    wr(4'd2, 32'h07); rd(4'd2, v); chk(v == 0, "R2 clear rest", v, 0);

    // R5 R6 R7 restart on compare 1
    wr(4'd4, 9); wr(4'd5, 5); wr(4'd6, 7);
    wr(4'd0, cw(1,1,1,0,0,0,1,3,4));
    waitc(30);
    rd(4'd2, v); chk(v == 32'h07, "R6 flags", v, 32'h07);
    for (int i = 0; i < 5; i++) begin
      rd(4'd9, v); chk(v <= 9, "R5 bound", v, 9); waitc(i);
    end
    cdiff(10, v); chk(v == 0, "R5 period", v, 0);
    begin
      logic p0; int lows;
      p0 = cmp_out[0]; waitc(10); chk(cmp_out[0] != p0, "R7 toggle", {31'd0, cmp_out[0]}, {31'd0, ~p0});
      waitc(10); chk(cmp_out[0] == p0, "R7 toggle back", {31'd0, cmp_out[0]}, {31'd0, p0});
      chk(cmp_out[1] == 1, "R7 set", {31'd0, cmp_out[1]}, 1);
      lows = 0;
      for (int i = 0; i < 40; i++) begin waitc(1); if (!cmp_out[2]) lows++; end
      chk(lows == 4, "R7 pulse", 32'(lows), 4);
    end
    wr(4'd0, cw(1,1,1,0,0,0,0,2,4)); waitc(12);
    chk(cmp_out[1] == 0, "R7 clear", {31'd0, cmp_out[1]}, 0);
    chk(cmp_out[0] == 0, "R7 off", {31'd0, cmp_out[0]}, 0);

    // R8 capture mode sweep on channel 1, count held
    wr(4'd0, 0); wr(4'd0, cw(1,1,1,1,0,0,0,0,0)); waitc(5);
    wr(4'd0, cw(1,1,0,1,0,3,0,0,0)); rd(4'd9, c2);
    for (int m = 0; m < 4; m++) begin
      wr(4'd0, cw(1,1,0,1,m,3,0,0,0)); wr(4'd2, 32'h3F);
      @(negedge clk); cap_in[0] = 1; waitc(5); rd(4'd2, v);
      chk(v[3] == m[0], $sformatf("R8 rise mode %0d", m), v, {28'd0, m[0], 3'd0});
      wr(4'd2, 32'h3F);
      @(negedge clk); cap_in[0] = 0; waitc(5); rd(4'd2, v);
      chk(v[3] == m[1], $sformatf("R8 fall mode %0d", m), v, {28'd0, m[1], 3'd0});
    end
    rd(4'd7, v); chk(v == c2, "R8 value 1", v, c2);
    wr(4'd2, 32'h3F);
    @(negedge clk); cap_in[1] = 1; waitc(5); rd(4'd2, v); chk(v == 32'h10, "R8 both rise", v, 32'h10);
    wr(4'd2, 32'h3F);
    @(negedge clk); cap_in[1] = 0; waitc(5); rd(4'd2, v); chk(v == 32'h10, "R8 both fall", v, 32'h10);
    rd(4'd8, v); chk(v == c2, "R8 value 2", v, c2);

    // R11 interrupt gating
    wr(4'd3, 32'h08); waitc(2); chk(irq == 0, "R11 masked", {31'd0, irq}, 0);
    wr(4'd3, 32'h10); waitc(2); chk(irq == 1, "R11 enabled", {31'd0, irq}, 1);
    wr(4'd2, 32'h10); waitc(2); chk(irq == 0, "R11 cleared", {31'd0, irq}, 0);

    // R10 soft reset
    wr(4'd1, 7); wr(4'd3, 32'h3F); wr(4'd4, 3);
    wr(4'd0, 32'h100); rd(4'd0, v); chk(v[8] == 1, "R10 busy", v, 32'h100);
    waitc(8);
    rd(4'd0, v); chk(v == 0, "R10 ctrl", v, 0);
    rd(4'd1, v); chk(v == 0, "R10 div", v, 0);
    rd(4'd3, v); chk(v == 0, "R10 ien", v, 0);
    rd(4'd4, v); chk(v == 0, "R10 cmp", v, 0);
    rd(4'd7, v); chk(v == 0, "R10 cap", v, 0);
    report();
  end
endmodule